// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Collector

The collector merges 64 interrupt request lines into one CPU interrupt output. Every source has a 2-bit level, an enable and a software-trigger bit. Among the pending, enabled sources that the current service state allows, the highest level wins, and a tie goes to the lowest source number. The winner's number is visible in a status register. A vector register returns a table base plus four times that number.

Software tells the collector that a handler has started, either by writing the vector register or, in read-entry mode, by reading it. The winner's level is then marked in service. A later write to the level-acknowledge register ends servicing on the levels named by its set bits. With nesting on, only a strictly higher level can interrupt a handler. With nesting off, nothing can interrupt a handler until every level has been acknowledged.

Every register is reached through a 32-bit register bus and decodes at four consecutive word addresses. The low two word-address bits pick plain write, OR, bit-clear or XOR. Read data appears one cycle after the read strobe.

Top module: `irq_collector`

## Requirements
- R1: After reset, cpuIrq is low and the config (byte 0x20), base (0x60), status (0x30) and source-slot registers all read zero.
- R2: A source is pending when (raw line OR software bit) AND enable. cpuIrq asserts only when config bit 0 is 1 and some pending source is eligible.
- R3: Among eligible sources the highest level wins, and equal levels go to the lowest number. Status bits 5:0 give the winner's number, or 0 when no source is eligible.
- R4: The vector register (byte 0x00) reads base + 4 × winner number. The base register (0x60) stores bits 31:2, and bits 1:0 read zero.
- R5: Source n sits in the register at byte 0x80 + 16 × (n / 4), in byte lane n mod 4. Within the lane, bits 1:0 are the level, bit 2 is the enable, bit 3 is the software trigger, and bits 7:4 read zero.
- R6: For config, base and slot registers, the byte offsets +0x0, +0x4, +0x8 and +0xC write, OR in, clear, and toggle the written bits respectively.
- R7: With config bit 2 = 0, a write to the vector register puts the winner's level in service. A read of it changes no service state.
- R8: With config bit 2 = 1, a read of the vector register puts the winner's level in service. A write to it changes no service state.
- R9: With nesting on (config bit 1 = 0), while a level is in service only sources with a strictly higher level than the highest in-service level are eligible.
- R10: With config bit 1 = 1, no source is eligible while any level is in service.
- R11: A write to the acknowledge register (byte 0x10) clears the in-service state of every level whose bit (bits 3:0) is set.
- R12: Registers at bytes 0x40 and 0x50 read the unmasked raw lines 31:0 and 63:32.
- R13: Read data is registered: it changes on the first clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 10 | Byte address bits 11:2 of the access |
| busWe | input | 1 | Write strobe; takes precedence over busRe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqLines | input | 64 | Raw interrupt request lines |
| cpuIrq | output | 1 | Interrupt request to the CPU |

## Verification
Entry into service and the arrival of a new, higher-level request can fall on the same clock edge. The bench provokes this in read-entry mode: it raises a level-3 line in the same cycle as it presents a vector read, while a level-2 source is already pending. The returned vector must then name the new source, and cpuIrq must drop because level 3 is now in service. After that line is released and level 3 is acknowledged, the earlier level-2 source must win again.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int IDX_W   = 8;

  localparam logic [IDX_W-1:0] IDX_VEC  = 8'd0;
  localparam logic [IDX_W-1:0] IDX_ACK  = 8'd1;
  localparam logic [IDX_W-1:0] IDX_CFG  = 8'd2;
  localparam logic [IDX_W-1:0] IDX_STAT = 8'd3;
  localparam logic [IDX_W-1:0] IDX_RAW  = 8'd4;
  localparam logic [IDX_W-1:0] IDX_BASE = 8'd6;
  localparam logic [IDX_W-1:0] IDX_SLOT = 8'd8;

  typedef enum logic [1:0] {OP_PUT = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_FLIP = 2'd3} aliasOpE;

  typedef struct packed {
    logic             wrCfg;
    logic             wrBase;
    logic             wrSlot;
    logic             wrAck;
    logic             goSvc;
    logic             rdEn;
    logic             slotHit;
    aliasOpE          op;
    logic [IDX_W-1:0] regIdx;
  } strobeT;

  function automatic logic [31:0] applyAlias(aliasOpE op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      OP_PUT:  return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:2] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              cfgReadGo,
  output strobeT            strb
);
  localparam int NUM_SLOTREG = NUM_SRC / 4;
  localparam logic [IDX_W-1:0] SLOT_END = IDX_W'(int'(IDX_SLOT) + NUM_SLOTREG);

  logic [IDX_W-1:0] idx;
  logic rdOnly;

  always_comb begin
    idx    = IDX_W'(busAddr[ADDR_W-1:4]);
    rdOnly = busRe && !busWe;
    strb.regIdx  = idx;
    strb.op      = aliasOpE'(busAddr[3:2]);
    strb.slotHit = (idx >= IDX_SLOT) && (idx < SLOT_END);
    strb.wrCfg   = busWe && (idx == IDX_CFG);
    strb.wrBase  = busWe && (idx == IDX_BASE);
    strb.wrSlot  = busWe && strb.slotHit;
    strb.wrAck   = busWe && (idx == IDX_ACK);
    strb.goSvc   = (idx == IDX_VEC) && (cfgReadGo ? rdOnly : busWe);
    strb.rdEn    = rdOnly;
  end

  // R6: a write lands on at most one storage target
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCfg, strb.wrBase, strb.wrSlot, strb.wrAck}));

  // R8: service entry by a read only happens in read-entry mode
  assert_read_entry_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goSvc && busRe && !busWe) |-> cfgReadGo);
endmodule

// File: rtl/irq_collector_dp.sv
module irq_collector_dp
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic [31:0]        rdata,
  output logic               cpuIrq,
  output logic               cfgReadGo
);
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int SEL_W      = SRC_W - 2;
  localparam int NUM_RAWREG = NUM_SRC / 32;

  logic [NUM_SRC-1:0][LVL_W-1:0] prioV;
  logic [NUM_SRC-1:0]            enV, softV, pend;
  logic                          cfgIrqEn, cfgNoNest;
  logic [29:0]                   baseHi;
  logic [NUM_LVL-1:0]            inSvc, lvlOk, ackMask, setMask;
  logic                          anySvc, found;
  logic [LVL_W-1:0]              topLvl, winLvl;
  logic [SRC_W-1:0]              winIdx;
  logic [SEL_W-1:0]              slotSel;
  logic [3:0]                    slotOldFld [4];
  logic [3:0]                    slotNewFld [4];
  logic [31:0]                   slotOld, vecAddr, rdNext;

  // slot access view
  always_comb begin
    slotSel = SEL_W'(strb.regIdx - IDX_SLOT);
    slotOld = '0;
    for (int k = 0; k < 4; k++) begin
      slotOldFld[k] = {1'b0, softV[{slotSel, 2'(k)}], enV[{slotSel, 2'(k)}], prioV[{slotSel, 2'(k)}]};
      slotNewFld[k] = 4'(applyAlias(strb.op, 32'(slotOldFld[k]), 32'(wdata[k*8 +: 4])));
      slotOld[k*8 +: 8] = {4'b0, slotOldFld[k]};
    end
  end

  // arbitration
  always_comb begin
    pend   = (irqLines | softV) & enV;
    anySvc = |inSvc;
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) if (inSvc[l]) topLvl = LVL_W'(l);
    for (int l = 0; l < NUM_LVL; l++)
      lvlOk[l] = cfgNoNest ? !anySvc : (!anySvc || (LVL_W'(l) > topLvl));
    found  = 1'b0;
    winIdx = '0;
    winLvl = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (pend[n] && lvlOk[prioV[n]] && (!found || prioV[n] >= winLvl)) begin
        found  = 1'b1;
        winIdx = SRC_W'(n);
        winLvl = prioV[n];
      end
    end
    cpuIrq  = cfgIrqEn && found;
    vecAddr = {baseHi + 30'(winIdx), 2'b00};
    ackMask = strb.wrAck ? wdata[NUM_LVL-1:0] : '0;
    setMask = (strb.goSvc && cpuIrq) ? (NUM_LVL'(1) << winLvl) : '0;
  end

  // read mux
  always_comb begin
    case (strb.regIdx)
      IDX_VEC:  rdNext = vecAddr;
      IDX_CFG:  rdNext = {29'b0, cfgReadGo, cfgNoNest, cfgIrqEn};
      IDX_STAT: rdNext = 32'(winIdx);
      IDX_BASE: rdNext = {baseHi, 2'b00};
      default:  rdNext = '0;
    endcase
    for (int r = 0; r < NUM_RAWREG; r++)
      if (strb.regIdx == IDX_W'(int'(IDX_RAW) + r)) rdNext = irqLines[r*32 +: 32];
    if (strb.slotHit) rdNext = slotOld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioV     <= '0;
      enV       <= '0;
      softV     <= '0;
      cfgIrqEn  <= 1'b0;
      cfgNoNest <= 1'b0;
      cfgReadGo <= 1'b0;
      baseHi    <= '0;
      inSvc     <= '0;
      rdata     <= '0;
    end else begin
      if (strb.wrCfg)
        {cfgReadGo, cfgNoNest, cfgIrqEn} <=
          3'(applyAlias(strb.op, {29'b0, cfgReadGo, cfgNoNest, cfgIrqEn}, wdata));
      if (strb.wrBase)
        baseHi <= 30'(applyAlias(strb.op, {baseHi, 2'b00}, wdata) >> 2);
      if (strb.wrSlot) begin
        for (int k = 0; k < 4; k++) begin
          prioV[{slotSel, 2'(k)}] <= slotNewFld[k][LVL_W-1:0];
          enV[{slotSel, 2'(k)}]   <= slotNewFld[k][2];
          softV[{slotSel, 2'(k)}] <= slotNewFld[k][3];
        end
      end
      inSvc <= (inSvc & ~ackMask) | setMask;
      if (strb.rdEn) rdata <= rdNext;
    end
  end

  // R2: the source named to the CPU is really pending
  assert_winner_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> pend[winIdx]);

  // R7: service entry marks the winning level on the next cycle
  assert_entry_marks_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goSvc && cpuIrq) |=> inSvc[$past(winLvl)]);

  // R9: nested requests sit strictly above the active level
  assert_nest_above_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNoNest && cpuIrq && anySvc) |-> (winLvl > topLvl));

  // R10: with nesting off, the CPU is only interrupted when idle
  assert_no_nest_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgNoNest && cpuIrq) |-> !anySvc);

  // R11: acknowledged levels leave service
  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck |=> ((inSvc & $past(wdata[NUM_LVL-1:0])) == '0));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:2]  busAddr,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic               cpuIrq
);
  strobeT strb;
  logic   cfgReadGo;

  irq_collector_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .cfgReadGo(cfgReadGo), .strb(strb)
  );

  irq_collector_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .irqLines(irqLines),
    .rdata(busRdata), .cpuIrq(cpuIrq), .cfgReadGo(cfgReadGo)
  );
endmodule

// File: tb/tb_irq_collector.sv
module tb_irq_collector;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h1234_5674;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:2] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] irqLines = '0;
  logic        cpuIrq;
  int total = 0;
  int bad = 0;

  irq_collector dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irqLines(irqLines), .cpuIrq(cpuIrq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(a >> 2); busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(a >> 2); busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0; d = busRdata;
  endtask

  task automatic setRaw(input logic [63:0] v);
    @(negedge clk);
    irqLines = v;
    #1;
  endtask

  task automatic chkStat(input string tag, input int n);
    logic [31:0] v;
    rd(32'h30, v);
    chk(tag, v, 32'(n));
  endtask

  function automatic int slotAddr(input int n);
    return 32'h80 + (n / 4) * 16;
  endfunction

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, pat, expW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 cpuIrq", 32'(cpuIrq), 0);
    rd(32'h20, v); chk("R1 config", v, 0);
    rd(32'h60, v); chk("R1 base", v, 0);
    rd(32'h30, v); chk("R1 status", v, 0);
    rd(32'h80, v); chk("R1 slot0", v, 0);

    // R5 R6: slot layout and aliases over every slot register
    for (int r = 0; r < 16; r++) begin
      pat = 32'hA5C3_F00F ^ (32'(r) * 32'h0101_0101);
      wr(32'h80 + r*16, pat);      expW = pat & 32'h0F0F_0F0F;
      rd(32'h80 + r*16, v); chk("R5 slot write", v, expW);
      wr(32'h84 + r*16, 32'h0801_0402); expW = expW | 32'h0801_0402;
      rd(32'h80 + r*16, v); chk("R6 slot set", v, expW);
      wr(32'h88 + r*16, 32'h0306_0C01); expW = expW & ~32'h0306_0C01;
      rd(32'h80 + r*16, v); chk("R6 slot clear", v, expW);
      wr(32'h8C + r*16, 32'hFF0F_F00F); expW = (expW ^ 32'hFF0F_F00F) & 32'h0F0F_0F0F;
      rd(32'h80 + r*16, v); chk("R6 slot toggle", v, expW);
      wr(32'h80 + r*16, 0);
    end

    // R4 R6: base keeps bits 31:2; config aliases
    wr(32'h60, 32'h1234_5677); rd(32'h60, v); chk("R4 base low bits", v, BASE);
    wr(32'h64, 32'h0000_0003); rd(32'h60, v); chk("R6 base set", v, BASE);
    wr(32'h24, 32'h5);  rd(32'h20, v); chk("R6 config set", v, 32'h5);
    wr(32'h2C, 32'h3);  rd(32'h20, v); chk("R6 config toggle", v, 32'h6);
    wr(32'h28, 32'h6);  rd(32'h20, v); chk("R6 config clear", v, 32'h0);
    wr(32'h20, 32'h1);

    // R13: read data changes only at the edge after the strobe
    rd(32'h60, v);
    @(negedge clk); busAddr = 10'(32'h20 >> 2); busRe = 1'b1; #1;
    chk("R13 before edge", busRdata, BASE);
    @(negedge clk); busRe = 1'b0;
    chk("R13 after edge", busRdata, 32'h1);

    // R2 R3 R4: each source alone, at level n mod 4
    for (int n = 0; n < 64; n++) begin
      setRaw(64'(1) << n);
      chk("R2 disabled source silent", 32'(cpuIrq), 0);
      wr(slotAddr(n) + 4, (32'h4 | 32'(n % 4)) << ((n % 4) * 8));
      #1; chk("R2 enabled source", 32'(cpuIrq), 1);
      chkStat("R3 status single", n);
      rd(32'h00, v); chk("R4 vector", v, BASE + 32'(4 * n));
      setRaw(64'h0);
      chk("R2 line dropped", 32'(cpuIrq), 0);
      wr(slotAddr(n) + 8, 32'hFF << ((n % 4) * 8));
    end
    chkStat("R3 status idle", 0);

    // R2: software trigger and global enable
    wr(slotAddr(10) + 4, 32'h0C << 16);
    #1; chk("R2 soft trigger", 32'(cpuIrq), 1);
    chkStat("R2 soft winner", 10);
    wr(32'h28, 32'h1); #1; chk("R2 global enable off", 32'(cpuIrq), 0);
    wr(32'h24, 32'h1);
    wr(slotAddr(10) + 8, 32'hFF << 16);

    // R3 R12: tie sweep at one level, then priority overrides
    for (int r = 0; r < 16; r++) wr(32'h80 + r*16, 32'h0505_0505);
    for (int k = 0; k < 64; k++) begin
      setRaw(64'hFFFF_FFFF_FFFF_FFFF << k);
      chkStat("R3 tie lowest number", k);
      if (k % 21 == 0) begin
        rd(32'h40, v); chk("R12 raw low", v, irqLines[31:0]);
        rd(32'h50, v); chk("R12 raw high", v, irqLines[63:32]);
      end
    end
    setRaw(64'hFFFF_FFFF_FFFF_FFFF);
    wr(slotAddr(50) + 4, 32'h02 << 16); chkStat("R3 higher level wins", 50);
    wr(slotAddr(20) + 4, 32'h02);       chkStat("R3 tie at top level", 20);
    setRaw(64'h0);
    for (int r = 0; r < 16; r++) wr(32'h80 + r*16, 0);

    // Nesting: src5 level 1, src9 level 2, src60 level 3
    wr(slotAddr(5), 32'h5 << 8);
    wr(slotAddr(9), 32'h6 << 8);
    wr(slotAddr(60), 32'h7);
    setRaw(64'(1) << 5);
    rd(32'h00, v); #1;
    chk("R7 read leaves state", 32'(cpuIrq), 1);
    wr(32'h00, 0); #1;
    chk("R7 write enters level 1", 32'(cpuIrq), 0);
    setRaw((64'(1) << 5) | (64'(1) << 9));
    chk("R9 higher level nests", 32'(cpuIrq), 1);
    chkStat("R9 nested winner", 9);
    wr(32'h00, 0); #1; chk("R9 level 2 in service", 32'(cpuIrq), 0);
    wr(32'h10, 32'h4); #1; chk("R11 ack level 2", 32'(cpuIrq), 1);
    chkStat("R11 winner after ack", 9);
    setRaw(64'(1) << 5);
    chk("R9 same level blocked", 32'(cpuIrq), 0);
    wr(32'h10, 32'h2); #1; chk("R11 ack level 1", 32'(cpuIrq), 1);

    // R10: nesting disabled
    wr(32'h24, 32'h2);
    wr(32'h00, 0);
    setRaw((64'(1) << 5) | (64'(1) << 9));
    chk("R10 no nesting", 32'(cpuIrq), 0);
    wr(32'h10, 32'h2); #1; chk("R10 released after ack", 32'(cpuIrq), 1);
    chkStat("R10 winner", 9);
    wr(32'h28, 32'h2);

    // R8: read-entry mode
    wr(32'h24, 32'h4);
    wr(32'h00, 0); #1; chk("R8 write ignored", 32'(cpuIrq), 1);
    rd(32'h00, v); #1;
    chk("R8 read vector", v, BASE + 32'd36);
    chk("R8 read enters level 2", 32'(cpuIrq), 0);
    wr(32'h10, 32'h4); #1; chk("R8 ack level 2", 32'(cpuIrq), 1);

    // Same-edge entry and new higher request
    @(negedge clk);
    busAddr = 10'(0); busRe = 1'b1; irqLines[60] = 1'b1;
    @(negedge clk);
    busRe = 1'b0; v = busRdata; #1;
    chk("R8 coincident vector", v, BASE + 32'd240);
    chk("R9 level 3 in service", 32'(cpuIrq), 0);
    setRaw((64'(1) << 5) | (64'(1) << 9));
    chk("R9 still blocked", 32'(cpuIrq), 0);
    wr(32'h10, 32'h8); #1; chk("R11 ack level 3", 32'(cpuIrq), 1);
    chkStat("R11 earlier winner back", 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule